// File: doc/BRIEF.md
# Dual-Channel Byte Transfer Sequencer

This block sequences single-byte transfers between a byte-wide peripheral port and a buffer memory. It keeps two transfer channels, remote (channel 0) and local (channel 1). For each channel a host loads a start address, a byte count and a direction.

While a channel has bytes left, the block asks an external bus arbiter for the bus one byte at a time. It raises a request and holds it until the arbiter acknowledges. In the next cycle it presents that channel's buffer address. In the same cycle it pulses a buffer write strobe if the channel moves data into the buffer. It then steps that channel's address up by one and its count down by one.

When both channels hold work, their bytes are interleaved one at a time in alternating order. Each channel raises its own done flag when its last byte has gone. Arbitration, the memory and the peripheral protocol sit outside the block.

Top module: `dual_dma_seq`

## Requirements
- R1: While reset is asserted, busReq, busAddrValid, bufWrStrobe and both doneFlag bits are 0.
- R2: busReq stays high until busAck is sampled high. It is low in the cycle after that acknowledge. It is also low in the cycle after every address cycle.
- R3: An address cycle comes exactly in the cycle after busReq and busAck are both high, and only then. In it, busAddrValid is 1, grantChan names the channel (0 remote, 1 local) and busAddr carries that channel's current address.
- R4: In an address cycle, bufWrStrobe is 1 exactly when the granted channel was loaded with cmdToBuf = 1 (into the buffer). It is 0 in every other cycle.
- R5: A channel's address rises by one after each of its bytes and wraps from 16'hFFFF to 16'h0000.
- R6: A channel loaded with count N performs exactly N address cycles. A count of 0 leaves the channel idle, with no request made for it.
- R7: When both channels have bytes left, grants alternate between them. The first grant after reset goes to remote if it is pending.
- R8: A channel's done flag rises in the cycle after its last address cycle. A start command for that channel clears it.
- R9: busAck sampled while busReq is low has no effect: no address cycle, request or flag change follows.
- R10: A start command (cmdStart = 1) loads address, count and direction only into the channel chosen by cmdChan. The other channel's state and done flag are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Load the selected channel for one cycle |
| cmdChan | input | 1 | Channel to load: 0 remote, 1 local |
| cmdAddr | input | 16 | Start buffer address |
| cmdCount | input | 16 | Number of bytes to move |
| cmdToBuf | input | 1 | 1 = data flows into the buffer |
| busReq | output | 1 | Request to the bus arbiter |
| busAck | input | 1 | Grant from the bus arbiter |
| busAddr | output | 16 | Buffer address of the current byte, 0 outside address cycles |
| busAddrValid | output | 1 | Address cycle marker |
| bufWrStrobe | output | 1 | Buffer write pulse |
| grantChan | output | 1 | Channel of the current address cycle |
| doneFlag | output | 2 | Per-channel done, bit 0 remote, bit 1 local |

## Verification
The assertions take for granted that the host never reloads a channel while a byte of that channel is between request and address cycle. They also assume busAck is a single-cycle pulse answering a visible request. Outside the deliberate idle-acknowledge window, the stimulus issues start commands only right after a reset or once every byte already loaded has been seen. Its acknowledge responder raises busAck only while busReq is observed high and drops it the next cycle. The one exception is a window where busAck is forced high with nothing pending, to show that it is ignored there.

// File: rtl/dual_dma_seq_pkg.sv
package dual_dma_seq_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance; // current byte done, step selected channel
    logic chan;    // selected channel
  } dpCtl_t;
endpackage

// File: rtl/dual_dma_seq_chan.sv
module dual_dma_seq_chan #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [CNT_W-1:0]  loadCount,
  input  logic              loadToBuf,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              toBuf,
  output logic              pending,
  output logic              done
);
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr   <= '0;
      countQ <= '0;
      toBuf  <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      addr   <= loadAddr;
      countQ <= loadCount;
      toBuf  <= loadToBuf;
      done   <= 1'b0;
    end else if (step) begin
      addr   <= addr + ADDR_W'(1);
      countQ <= countQ - CNT_W'(1);
      if (countQ == CNT_W'(1)) begin
        done <= 1'b1;
      end
    end
  end

  assign pending = (countQ != '0);
endmodule

// File: rtl/dual_dma_seq_dp.sv
module dual_dma_seq_dp
  import dual_dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdChan,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic              cmdToBuf,
  input  dpCtl_t            ctl,
  output logic [NUM_CH-1:0] pending,
  output logic [ADDR_W-1:0] curAddr,
  output logic              curToBuf,
  output logic [NUM_CH-1:0] doneFlag
);
  logic [NUM_CH-1:0][ADDR_W-1:0] chAddr;
  logic [NUM_CH-1:0]             chToBuf;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    dual_dma_seq_chan #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
    ) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .load     (cmdStart && (cmdChan == 1'(g))),
      .loadAddr (cmdAddr),
      .loadCount(cmdCount),
      .loadToBuf(cmdToBuf),
      .step     (ctl.advance && (ctl.chan == 1'(g))),
      .addr     (chAddr[g]),
      .toBuf    (chToBuf[g]),
      .pending  (pending[g]),
      .done     (doneFlag[g])
    );
  end

  assign curAddr  = chAddr[ctl.chan];
  assign curToBuf = chToBuf[ctl.chan];
endmodule

// File: rtl/dual_dma_seq_ctl.sv
module dual_dma_seq_ctl
  import dual_dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pending,
  input  logic              busAck,
  output logic              busReq,
  output logic              addrValid,
  output dpCtl_t            ctl
);
  seqState_e stateQ;
  logic      selQ;
  logic      lastQ;
  logic      nextSel;

  // alternate when both wait; otherwise take the one that waits
  always_comb begin
    if (pending == 2'b11) begin
      nextSel = ~lastQ;
    end else begin
      nextSel = pending[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      selQ   <= 1'b0;
      lastQ  <= 1'b1; // so remote wins the first tie
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (|pending) begin
            stateQ <= ST_REQ;
            selQ   <= nextSel;
          end
        end
        ST_REQ: begin
          if (busAck) begin
            stateQ <= ST_XFER;
          end
        end
        ST_XFER: begin
          stateQ <= ST_IDLE;
          lastQ  <= selQ;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busReq      = (stateQ == ST_REQ);
  assign addrValid   = (stateQ == ST_XFER);
  assign ctl.advance = (stateQ == ST_XFER);
  assign ctl.chan    = selQ;
endmodule

// File: rtl/dual_dma_seq.sv
module dual_dma_seq
  import dual_dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdChan,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic              cmdToBuf,
  output logic              busReq,
  input  logic              busAck,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrValid,
  output logic              bufWrStrobe,
  output logic              grantChan,
  output logic [1:0]        doneFlag
);
  dpCtl_t            ctl;
  logic [NUM_CH-1:0] pending;
  logic [ADDR_W-1:0] curAddr;
  logic              curToBuf;
  logic              addrValid;

  dual_dma_seq_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .pending  (pending),
    .busAck   (busAck),
    .busReq   (busReq),
    .addrValid(addrValid),
    .ctl      (ctl)
  );

  dual_dma_seq_dp #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmdStart(cmdStart),
    .cmdChan (cmdChan),
    .cmdAddr (cmdAddr),
    .cmdCount(cmdCount),
    .cmdToBuf(cmdToBuf),
    .ctl     (ctl),
    .pending (pending),
    .curAddr (curAddr),
    .curToBuf(curToBuf),
    .doneFlag(doneFlag)
  );

  assign busAddrValid = addrValid;
  assign busAddr      = addrValid ? curAddr : '0;
  assign bufWrStrobe  = addrValid & curToBuf;
  assign grantChan    = ctl.chan;
endmodule

// File: rtl/dual_dma_seq_chk.sv
module dual_dma_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdStart,
  input logic       cmdChan,
  input logic       busReq,
  input logic       busAck,
  input logic       busAddrValid,
  input logic       bufWrStrobe,
  input logic       grantChan,
  input logic [1:0] doneFlag
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq);

  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> !busReq);

  assert_req_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    busAddrValid |=> !busReq);

  assert_addr_follows_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> busAddrValid);

  assert_addr_needs_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    busAddrValid |-> $past(busReq && busAck));

  assert_strobe_in_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    bufWrStrobe |-> busAddrValid);

  assert_remote_done_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag[0]) |-> $past(busAddrValid && !grantChan));

  assert_local_done_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag[1]) |-> $past(busAddrValid && grantChan));

  assert_remote_done_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart && !cmdChan |=> !doneFlag[0]);

  assert_local_done_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart && cmdChan |=> !doneFlag[1]);
endmodule

bind dual_dma_seq dual_dma_seq_chk u_chk (.*);

// File: tb/dual_dma_seq_bench.sv
module dual_dma_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic        cmdChan = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic [15:0] cmdCount = '0;
  logic        cmdToBuf = 1'b0;
  logic        busReq;
  logic        busAck = 1'b0;
  logic [15:0] busAddr;
  logic        busAddrValid;
  logic        bufWrStrobe;
  logic        grantChan;
  logic [1:0]  doneFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] expAddr [2];
  int          remain [2];
  logic        expDir [2];
  int          lastCh = 1;
  int          seen = 0;
  bit          prevValid = 0;
  bit          autoAck = 0;
  bit          forceAck = 0;
  int          ackLat = 0;
  int          waitCnt = 0;

  always #10 clk = ~clk;

  dual_dma_seq u_dual_dma_seq (
    .clk         (clk),
    .rstN        (rstN),
    .cmdStart    (cmdStart),
    .cmdChan     (cmdChan),
    .cmdAddr     (cmdAddr),
    .cmdCount    (cmdCount),
    .cmdToBuf    (cmdToBuf),
    .busReq      (busReq),
    .busAck      (busAck),
    .busAddr     (busAddr),
    .busAddrValid(busAddrValid),
    .bufWrStrobe (bufWrStrobe),
    .grantChan   (grantChan),
    .doneFlag    (doneFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor, reference model and acknowledge responder
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
      if (rstN) begin
        if (prevValid) check(!busReq, "R2", "request gap after address cycle", busReq, 0);
        if (busAddrValid) begin
          int ch;
          bit known;
          known = 1;
          if (remain[0] > 0 && remain[1] > 0) ch = 1 - lastCh;
          else if (remain[0] > 0) ch = 0;
          else if (remain[1] > 0) ch = 1;
          else begin
            known = 0;
            ch = 0;
          end
          if (!known) begin
            check(0, "R6", "address cycle with no bytes left", 1, 0);
          end else begin
            check(grantChan == 1'(ch), "R7", "grant channel", grantChan, ch);
            check(busAddr == expAddr[ch], "R3_R5", "buffer address", busAddr, expAddr[ch]);
            check(bufWrStrobe == expDir[ch], "R4", "write strobe", bufWrStrobe, expDir[ch]);
            check(!busReq, "R2", "request low in address cycle", busReq, 0);
            expAddr[ch] = expAddr[ch] + 16'd1;
            remain[ch]--;
            lastCh = ch;
            seen++;
          end
        end else if (bufWrStrobe) begin
          check(0, "R4", "strobe outside address cycle", 1, 0);
        end
        prevValid = busAddrValid;
      end
      if (forceAck) busAck = 1'b1;
      else if (busAck) begin
        busAck = 1'b0;
        waitCnt = 0;
      end else if (autoAck && busReq) begin
        if (waitCnt >= ackLat) busAck = 1'b1;
        else waitCnt++;
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cmdStart = 1'b0;
    autoAck = 0;
    @(negedge clk);
    check(!busReq && !busAddrValid && !bufWrStrobe, "R1", "outputs in reset",
          {busReq, busAddrValid, bufWrStrobe}, 0);
    check(doneFlag == 2'b00, "R1", "done flags in reset", doneFlag, 0);
    rstN = 1'b1;
    lastCh = 1;
    seen = 0;
    prevValid = 0;
    waitCnt = 0;
    remain[0] = 0;
    remain[1] = 0;
  endtask

  task automatic startCh(input int ch, input logic [15:0] a, input int n, input logic d);
    @(negedge clk);
    expAddr[ch] = a;
    remain[ch] = n;
    expDir[ch] = d;
    cmdStart = 1'b1;
    cmdChan = 1'(ch);
    cmdAddr = a;
    cmdCount = 16'(n);
    cmdToBuf = d;
  endtask

  task automatic waitBytes(input int total);
    int guard;
    guard = 0;
    while (seen < total && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    check(seen == total, "R6", "byte total", seen, total);
    check(!busReq, "R6", "no request once counts are spent", busReq, 0);
  endtask

  task automatic runCase(input logic [15:0] aR, input int nR, input logic dR,
                         input logic [15:0] aL, input int nL, input logic dL,
                         input int lat);
    doReset();
    ackLat = lat;
    autoAck = 1;
    startCh(0, aR, nR, dR);
    startCh(1, aL, nL, dL);
    @(negedge clk);
    cmdStart = 1'b0;
    waitBytes(nR + nL);
    check(doneFlag[0] == (nR != 0), "R8", "remote done", doneFlag[0], nR != 0);
    check(doneFlag[1] == (nL != 0), "R8", "local done", doneFlag[1], nL != 0);
  endtask

  initial begin
    remain[0] = 0;
    remain[1] = 0;
    expAddr[0] = '0;
    expAddr[1] = '0;
    expDir[0] = 0;
    expDir[1] = 0;

    // sweep counts, directions and acknowledge latency (R3 R4 R5 R6 R7 R8)
    for (int lat = 0; lat < 3; lat++) begin
      for (int nR = 0; nR < 4; nR++) begin
        for (int nL = 0; nL < 4; nL++) begin
          runCase(16'h1000 + 16'(nR * 16), nR, 1'((nR + lat) % 2),
                  16'h2000 + 16'(nL * 32), nL, 1'((nL + lat + 1) % 2), lat);
        end
      end
    end

    // address wrap on both channels (R5)
    runCase(16'hFFFE, 4, 1'b1, 16'hFFFF, 3, 1'b0, 1);

    // acknowledge with nothing pending is ignored (R9)
    forceAck = 1;
    repeat (6) begin
      @(negedge clk);
      check(!busReq && !busAddrValid, "R9", "idle acknowledge ignored",
            {busReq, busAddrValid}, 0);
      check(doneFlag == 2'b11, "R9", "done flags kept under idle acknowledge", doneFlag, 3);
    end
    forceAck = 0;
    @(negedge clk);

    // reload remote with zero count: clears its done only (R8 R10 R6)
    startCh(0, 16'h4000, 0, 1'b1);
    @(negedge clk);
    cmdStart = 1'b0;
    check(doneFlag[0] == 1'b0, "R8", "start clears remote done", doneFlag[0], 0);
    check(doneFlag[1] == 1'b1, "R10", "local done untouched", doneFlag[1], 1);
    repeat (3) @(negedge clk);
    check(!busReq, "R6", "zero count stays idle", busReq, 0);

    // reload local only; remote stays idle (R10)
    seen = 0;
    startCh(1, 16'h0100, 2, 1'b1);
    @(negedge clk);
    cmdStart = 1'b0;
    check(doneFlag[1] == 1'b0, "R8", "start clears local done", doneFlag[1], 0);
    waitBytes(2);
    check(doneFlag == 2'b10, "R10", "only local done after local reload", doneFlag, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule